// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Port

This block is a full-duplex asynchronous serial port. It frames bytes for transmission and recovers bytes from a receive line. Both directions are timed by a tick pulse that runs at sixteen times the bit rate. One tick input serves the variable-rate modes. A second tick input serves the fixed-rate mode. The generation of both tick streams lies outside the block.

Software reaches the block through a small register bus. One address holds an eight-bit control and status register. The other address holds the data register. A write to the data register starts a transmission, and a read from it returns the receive buffer. There are two frame lengths. The short frame carries a start bit, eight data bits and a stop bit. The long frame adds a ninth data bit: it is sent from a software-set bit and captured into a receive-side bit.

The receiver decides each bit by a majority vote on three oversampled points near the bit centre. It drops start edges that do not hold. It only hands a frame to software when the previous frame has been collected. An optional multiprocessor filter lets a listening node ignore everything except address frames. The completion flags of both directions are ORed onto one interrupt line.

Top module: `uart_serial_port`

## Requirements
- R1: Each received bit takes the majority of three line samples, taken on ticks 7, 8 and 9 of its 16-tick bit time, counted from the tick on which the start edge was seen (tick 0). A disturbance that alters only one of the three samples does not change the received value.
- R2: When the vote on the start bit gives a one, the frame is abandoned, no flag is set, and the receiver returns to hunting for a start edge.
- R3: The control register (address 0) layout, bit 7 down to bit 0, is: mode[1:0], mp_filter, rx_enable, tx_bit8, rx_bit8, tx_flag, rx_flag. Mode 01 selects the 10-bit frame on tick_var. Mode 10 selects the 11-bit frame on tick_fix. Mode 11 selects the 11-bit frame on tick_var. Mode 00 keeps both directions idle: a data write sends nothing and txd stays high.
- R4: On the vote (tick 9) of the final frame bit, if rx_flag is clear, the received byte moves into the receive buffer (read at address 1). At the same moment rx_bit8 takes the ninth data bit in the 11-bit modes, or the stop bit in the 10-bit mode, and rx_flag is set.
- R5: When a frame completes while rx_flag is still set, the receive buffer and rx_bit8 keep their old contents (overrun).
- R6: With mp_filter set, an 11-bit frame is only delivered when its ninth data bit is 1. A 10-bit frame is only delivered when its stop bit votes 1.
- R7: A transmitted frame is a low start bit, then the data LSB first, then tx_bit8 in the 11-bit modes, then a high stop bit, each lasting 16 ticks. tx_flag is set when the stop bit begins.
- R8: A write to the data register starts a transmission even when tx_flag is already set.
- R9: With rx_enable clear, the receiver is held idle, and frames on rxd leave rx_flag and the buffer unchanged.
- R10: irq is high exactly when tx_flag or rx_flag is set. Both flags stay set until software writes the control register with them cleared.
- R11: After reset the control register and receive buffer read zero, txd is high and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_var | input | 1 | 16x bit-rate pulse for modes 01 and 11 |
| tick_fix | input | 1 | 16x bit-rate pulse for mode 10 |
| rxd | input | 1 | Serial receive line, idle high |
| bus_sel | input | 1 | Register select: 0 control, 1 data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| txd | output | 1 | Serial transmit line, idle high |
| irq | output | 1 | Interrupt request, OR of the two flags |

## Verification
The receiver is fed clean frames, frames with a one-tick disturbance centred on a data bit, and a short low pulse that imitates a start edge. These separate a correct majority vote and start rejection from plain centre sampling. Back-to-back frames with the flag left set, with it cleared, and with the multiprocessor filter set against address and non-address frames show whether the hand-off rule and the filter gate the buffer correctly. The transmitter is run in all three frame modes and in the idle mode, at both tick rates and with the flag already set. A bench-side decoder checks bit order, the ninth bit and the stop level, and the flag is timed against the start of the stop bit.

// File: rtl/uart_port_pkg.sv
package uart_port_pkg;

  // Frame mode held in control bits [7:6]
  typedef enum logic [1:0] {
    MODE_OFF     = 2'd0,
    MODE_10B     = 2'd1,
    MODE_11B_FIX = 2'd2,
    MODE_11B_VAR = 2'd3
  } port_mode_e;

  localparam int BYTE_W = 8;

endpackage

// File: rtl/uart_port_tx.sv
module uart_port_tx
  import uart_port_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start,
  input  port_mode_e        mode,
  input  logic              bit8,
  input  logic [DATA_W-1:0] data,
  output logic              txd,
  output logic              set_ti
);

  localparam int FW = DATA_W + 3;
  localparam int IW = $clog2(FW);
  localparam int CW = $clog2(OVS);
  localparam logic [IW-1:0] LAST_LONG  = IW'(DATA_W + 2);
  localparam logic [IW-1:0] LAST_SHORT = IW'(DATA_W + 1);
  localparam logic [CW-1:0] CNT_END    = CW'(OVS - 1);

  logic          busy_q, long_q;
  logic [FW-1:0] frame_q;
  logic [IW-1:0] idx_q, last_idx;
  logic [CW-1:0] cnt_q;
  logic          bit_end;

  assign last_idx = long_q ? LAST_LONG : LAST_SHORT;
  assign bit_end  = busy_q && tick && (cnt_q == CNT_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      long_q  <= 1'b0;
      frame_q <= '1;
      idx_q   <= '0;
      cnt_q   <= '0;
    end else if (start && (mode != MODE_OFF)) begin
      busy_q  <= 1'b1;
      long_q  <= (mode != MODE_10B);
      idx_q   <= '0;
      cnt_q   <= '0;
      frame_q <= {1'b1, (mode == MODE_10B) ? 1'b1 : bit8, data, 1'b0};
    end else if (busy_q && tick) begin
      if (cnt_q == CNT_END) begin
        cnt_q <= '0;
        if (idx_q == last_idx) busy_q <= 1'b0;
        else                   idx_q  <= idx_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // flag rises as the stop bit begins
  assign set_ti = bit_end && (idx_q == last_idx - 1'b1);
  assign txd    = busy_q ? frame_q[idx_q] : 1'b1;

  assert_tx_start_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode != MODE_OFF) |=> !txd);

  assert_ti_at_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set_ti |=> (busy_q && txd));

  assert_off_mode_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode == MODE_OFF && !busy_q) |=> (!busy_q && txd));

endmodule

// File: rtl/uart_port_rx.sv
module uart_port_rx
  import uart_port_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx_en,
  input  port_mode_e        mode,
  input  logic              mp_en,
  input  logic              ri_flag,
  input  logic              rxd,
  output logic              deliver,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit8
);

  localparam int FW = DATA_W + 3;
  localparam int IW = $clog2(FW);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] SMP_A   = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] SMP_B   = CW'(OVS/2);
  localparam logic [CW-1:0] SMP_C   = CW'(OVS/2 + 1);
  localparam logic [CW-1:0] CNT_END = CW'(OVS - 1);
  localparam logic [IW-1:0] LAST_LONG  = IW'(DATA_W + 2);
  localparam logic [IW-1:0] LAST_SHORT = IW'(DATA_W + 1);
  localparam logic [IW-1:0] IDX_B8     = IW'(DATA_W + 1);
  localparam logic [IW-1:0] IDX_DMAX   = IW'(DATA_W);

  typedef enum logic {RX_IDLE, RX_RUN} rx_state_e;

  rx_state_e         st_q;
  logic              meta_q, sync_q;
  logic              s_a_q, s_b_q;
  logic [CW-1:0]     cnt_q;
  logic [IW-1:0]     idx_q, last_idx;
  logic [DATA_W-1:0] shreg_q;
  logic              b8_q, long_q;
  logic              vote, vote_tick, is_data, is_b8, accept;

  assign vote      = (s_a_q & s_b_q) | (s_a_q & sync_q) | (s_b_q & sync_q);
  assign vote_tick = (st_q == RX_RUN) && tick && (cnt_q == SMP_C);
  assign last_idx  = long_q ? LAST_LONG : LAST_SHORT;
  assign is_data   = (idx_q != '0) && (idx_q <= IDX_DMAX);
  assign is_b8     = long_q && (idx_q == IDX_B8);
  assign accept    = !mp_en || (long_q ? b8_q : vote);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
    end else begin
      meta_q <= rxd;
      sync_q <= meta_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      s_a_q   <= 1'b1;
      s_b_q   <= 1'b1;
      shreg_q <= '0;
      b8_q    <= 1'b0;
      long_q  <= 1'b0;
    end else if (!rx_en || mode == MODE_OFF) begin
      st_q  <= RX_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
    end else if (tick) begin
      if (st_q == RX_IDLE) begin
        if (!sync_q) begin
          st_q   <= RX_RUN;
          cnt_q  <= CW'(1);
          idx_q  <= '0;
          long_q <= (mode != MODE_10B);
        end
      end else begin
        if (cnt_q == SMP_A) s_a_q <= sync_q;
        if (cnt_q == SMP_B) s_b_q <= sync_q;
        if (cnt_q == SMP_C) begin
          if (is_data) shreg_q <= {vote, shreg_q[DATA_W-1:1]};
          if (is_b8)   b8_q    <= vote;
        end
        if ((cnt_q == SMP_C) && (idx_q == '0) && vote) begin
          st_q  <= RX_IDLE;
          cnt_q <= '0;
        end else if (cnt_q == CNT_END) begin
          cnt_q <= '0;
          if (idx_q == last_idx) st_q  <= RX_IDLE;
          else                   idx_q <= idx_q + 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign deliver = vote_tick && (idx_q == last_idx) && !ri_flag && accept;
  assign rx_data = shreg_q;
  assign rx_bit8 = long_q ? b8_q : vote;

  assert_false_start_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (vote_tick && idx_q == '0 && vote) |=> (st_q == RX_IDLE));

  assert_disabled_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (st_q == RX_IDLE));

endmodule

// File: rtl/uart_serial_port.sv
module uart_serial_port
  import uart_port_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_var,
  input  logic              tick_fix,
  input  logic              rxd,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              txd,
  output logic              irq
);

  port_mode_e        mode_q;
  logic              mp_q, ren_q, tb8_q, rb8_q, ti_q, ri_q;
  logic [BYTE_W-1:0] rx_buf_q;
  logic              tick_sel, ctrl_wr, data_wr;
  logic              tx_set_ti, rx_deliver, rx_bit8;
  logic [BYTE_W-1:0] rx_data;

  assign tick_sel = (mode_q == MODE_11B_FIX) ? tick_fix : tick_var;
  assign ctrl_wr  = bus_wr && !bus_sel;
  assign data_wr  = bus_wr && bus_sel;

  uart_port_tx #(.DATA_W(BYTE_W), .OVS(OVS)) u_tx (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_sel),
    .start  (data_wr),
    .mode   (mode_q),
    .bit8   (tb8_q),
    .data   (bus_wdata),
    .txd    (txd),
    .set_ti (tx_set_ti)
  );

  uart_port_rx #(.DATA_W(BYTE_W), .OVS(OVS)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_sel),
    .rx_en   (ren_q),
    .mode    (mode_q),
    .mp_en   (mp_q),
    .ri_flag (ri_q),
    .rxd     (rxd),
    .deliver (rx_deliver),
    .rx_data (rx_data),
    .rx_bit8 (rx_bit8)
  );

  // software writes first, hardware set events override in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_OFF;
      mp_q     <= 1'b0;
      ren_q    <= 1'b0;
      tb8_q    <= 1'b0;
      rb8_q    <= 1'b0;
      ti_q     <= 1'b0;
      ri_q     <= 1'b0;
      rx_buf_q <= '0;
    end else begin
      if (ctrl_wr) begin
        mode_q <= port_mode_e'(bus_wdata[7:6]);
        mp_q   <= bus_wdata[5];
        ren_q  <= bus_wdata[4];
        tb8_q  <= bus_wdata[3];
        rb8_q  <= bus_wdata[2];
        ti_q   <= bus_wdata[1];
        ri_q   <= bus_wdata[0];
      end
      if (tx_set_ti) ti_q <= 1'b1;
      if (rx_deliver) begin
        ri_q     <= 1'b1;
        rb8_q    <= rx_bit8;
        rx_buf_q <= rx_data;
      end
    end
  end

  assign bus_rdata = bus_sel ? rx_buf_q
                             : {mode_q, mp_q, ren_q, tb8_q, rb8_q, ti_q, ri_q};
  assign irq = ti_q | ri_q;

  assert_load_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_deliver |=> (ri_q && rx_buf_q == $past(rx_data)));

  assert_overrun_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ri_q && !ctrl_wr) |=> ($stable(rx_buf_q) && $stable(rb8_q) && ri_q));

endmodule

// File: tb/tb_uart_serial_port.sv
module tb_uart_serial_port;

  localparam int CLK_P = 10;
  localparam int VDIV  = 4;
  localparam int FDIV  = 6;
  localparam int OVS   = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_var = 1'b0;
  logic       tick_fix = 1'b0;
  logic       rxd = 1'b1;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       txd, irq;

  int n_chk = 0;
  int n_bad = 0;
  int vc = 0;
  int fc = 0;
  int mon_bitclk = OVS * VDIV;
  logic [9:0] exp_q[$];

  uart_serial_port #(.OVS(OVS)) dut (
    .clk(clk), .rst_n(rst_n), .tick_var(tick_var), .tick_fix(tick_fix),
    .rxd(rxd), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .txd(txd), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    vc <= (vc == VDIV-1) ? 0 : vc + 1;
    fc <= (fc == FDIV-1) ? 0 : fc + 1;
    tick_var <= (vc == VDIV-1);
    tick_fix <= (fc == FDIV-1);
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [7:0] v);
    @(negedge clk);
    bus_sel = s; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic s, output logic [7:0] v);
    @(negedge clk);
    bus_sel = s;
    #1 v = bus_rdata;
  endtask

  function automatic logic [7:0] cw(input logic [1:0] m, input logic sm2, input logic ren, input logic tb8);
    return {m, sm2, ren, tb8, 3'b000};
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive one frame on rxd; gbit picks a frame bit that gets a one-tick inversion near its centre
  task automatic send_rx(input logic [7:0] d, input logic b8, input logic stp,
                         input bit is11, input int div, input int gbit);
    int bc;
    int n;
    logic [10:0] fr;
    bc = OVS * div;
    n  = is11 ? 11 : 10;
    fr = is11 ? {stp, b8, d, 1'b0} : {1'b0, stp, d, 1'b0};
    for (int i = 0; i < n; i++) begin
      if (i == gbit) begin
        rxd = fr[i];  wait_clk(8*div);
        rxd = ~fr[i]; wait_clk(div);
        rxd = fr[i];  wait_clk(bc - 9*div);
      end else begin
        rxd = fr[i];  wait_clk(bc);
      end
    end
    rxd = 1'b1;
    wait_clk(2*bc);
  endtask

  // scoreboard monitor: decode txd and compare with queued items {is11, bit8, data}
  initial begin
    forever begin
      logic [9:0] item;
      logic [9:0] got;
      logic [9:0] want;
      logic       st;
      int         nb;
      @(negedge txd);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected frame", 32'd1, 32'd0);
      end else begin
        item = exp_q.pop_front();
        nb   = item[9] ? 10 : 9;
        got  = '0;
        wait_clk(mon_bitclk/2);
        st = txd;
        for (int j = 0; j < nb; j++) begin
          wait_clk(mon_bitclk);
          got[j] = txd;
        end
        want = item[9] ? {1'b1, item[8], item[7:0]} : {1'b0, 1'b1, item[7:0]};
        chk(st == 1'b0 && got == want, "R7 tx frame", {22'd0, got}, {22'd0, want});
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int lows;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(2);

    // R11 reset state
    rd(1'b0, v); chk(v == 8'h00, "R11 ctrl after reset", {24'd0, v}, 32'h00);
    rd(1'b1, v); chk(v == 8'h00, "R11 buffer after reset", {24'd0, v}, 32'h00);
    chk(txd === 1'b1 && irq === 1'b0, "R11 txd/irq idle", {30'd0, txd, irq}, 32'h2);

    // ---------------- receive path, 10-bit mode ----------------
    wr(1'b0, cw(2'b01, 1'b0, 1'b1, 1'b0));
    send_rx(8'hA5, 1'b0, 1'b1, 1'b0, VDIV, -1);
    rd(1'b1, v); chk(v == 8'hA5, "R4 buffer loaded", {24'd0, v}, 32'hA5);
    rd(1'b0, v); chk(v[0] && v[2], "R4 rx flag and stop into rx_bit8", {24'd0, v}, 32'h55);
    chk(irq === 1'b1, "R10 irq from rx flag", {31'd0, irq}, 32'd1);

    send_rx(8'h3C, 1'b0, 1'b1, 1'b0, VDIV, -1);
    rd(1'b1, v); chk(v == 8'hA5, "R5 overrun keeps buffer", {24'd0, v}, 32'hA5);

    wr(1'b0, cw(2'b01, 1'b0, 1'b1, 1'b0));
    wait_clk(2);
    chk(irq === 1'b0, "R10 irq clears with flags", {31'd0, irq}, 32'd0);
    send_rx(8'h3C, 1'b0, 1'b1, 1'b0, VDIV, -1);
    rd(1'b1, v); chk(v == 8'h3C, "R4 second frame after clear", {24'd0, v}, 32'h3C);

    // R2 false start
    wr(1'b0, cw(2'b01, 1'b0, 1'b1, 1'b0));
    rxd = 1'b0; wait_clk(3*VDIV); rxd = 1'b1;
    wait_clk(3*OVS*VDIV);
    rd(1'b0, v); chk(v[0] == 1'b0, "R2 short pulse gives no frame", {24'd0, v}, 32'h50);
    send_rx(8'h5A, 1'b0, 1'b1, 1'b0, VDIV, -1);
    rd(1'b1, v); chk(v == 8'h5A, "R2 receiver hunts again after reject", {24'd0, v}, 32'h5A);

    // R1 single-sample disturbance in a 1 bit and in a 0 bit
    wr(1'b0, cw(2'b01, 1'b0, 1'b1, 1'b0));
    send_rx(8'hC3, 1'b0, 1'b1, 1'b0, VDIV, 2);
    rd(1'b1, v); chk(v == 8'hC3, "R1 vote masks glitch on 1 bit", {24'd0, v}, 32'hC3);
    wr(1'b0, cw(2'b01, 1'b0, 1'b1, 1'b0));
    send_rx(8'hC3, 1'b0, 1'b1, 1'b0, VDIV, 4);
    rd(1'b1, v); chk(v == 8'hC3, "R1 vote masks glitch on 0 bit", {24'd0, v}, 32'hC3);

    // R6 10-bit filter on stop bit
    wr(1'b0, cw(2'b01, 1'b1, 1'b1, 1'b0));
    send_rx(8'h17, 1'b0, 1'b0, 1'b0, VDIV, -1);
    rd(1'b0, v); chk(v[0] == 1'b0, "R6 bad stop not delivered", {24'd0, v}, 32'h70);
    send_rx(8'h18, 1'b0, 1'b1, 1'b0, VDIV, -1);
    rd(1'b1, v); chk(v == 8'h18, "R6 good stop delivered", {24'd0, v}, 32'h18);

    // R6 11-bit filter on ninth bit
    wr(1'b0, cw(2'b11, 1'b1, 1'b1, 1'b0));
    send_rx(8'h11, 1'b0, 1'b1, 1'b1, VDIV, -1);
    rd(1'b0, v); chk(v[0] == 1'b0, "R6 data frame filtered", {24'd0, v}, 32'hF0);
    send_rx(8'h22, 1'b1, 1'b1, 1'b1, VDIV, -1);
    rd(1'b1, v); chk(v == 8'h22, "R6 address frame delivered", {24'd0, v}, 32'h22);
    rd(1'b0, v); chk(v[2] && v[0], "R4 ninth bit into rx_bit8", {24'd0, v}, 32'hF5);

    // R3 fixed-rate 11-bit mode
    wr(1'b0, cw(2'b10, 1'b0, 1'b1, 1'b0));
    send_rx(8'h99, 1'b0, 1'b1, 1'b1, FDIV, -1);
    rd(1'b1, v); chk(v == 8'h99, "R3 fixed-rate frame", {24'd0, v}, 32'h99);
    rd(1'b0, v); chk(v[2] == 1'b0 && v[0], "R4 ninth bit zero", {24'd0, v}, 32'h91);

    // R9 receiver disabled
    wr(1'b0, cw(2'b01, 1'b0, 1'b0, 1'b0));
    send_rx(8'hEE, 1'b0, 1'b1, 1'b0, VDIV, -1);
    rd(1'b0, v); chk(v[0] == 1'b0, "R9 no flag when disabled", {24'd0, v}, 32'h40);
    rd(1'b1, v); chk(v == 8'h99, "R9 buffer unchanged when disabled", {24'd0, v}, 32'h99);

    // ---------------- transmit path ----------------
    wr(1'b0, cw(2'b01, 1'b0, 1'b0, 1'b0));
    mon_bitclk = OVS * VDIV;
    exp_q.push_back({1'b0, 1'b1, 8'h96});
    wr(1'b1, 8'h96);
    wait_clk(9*OVS*VDIV - 32);
    rd(1'b0, v); chk(v[1] == 1'b0, "R7 tx flag low before stop", {24'd0, v}, 32'h40);
    wait_clk(64);
    rd(1'b0, v); chk(v[1] == 1'b1, "R7 tx flag set at stop", {24'd0, v}, 32'h42);
    wait_clk(2*OVS*VDIV);
    chk(irq === 1'b1, "R10 irq from tx flag", {31'd0, irq}, 32'd1);

    exp_q.push_back({1'b0, 1'b1, 8'h0F});
    wr(1'b1, 8'h0F);
    wait_clk(12*OVS*VDIV);
    chk(exp_q.size() == 0, "R8 send with flag set", exp_q.size(), 32'd0);

    wr(1'b0, cw(2'b11, 1'b0, 1'b0, 1'b1));
    exp_q.push_back({1'b1, 1'b1, 8'h41});
    wr(1'b1, 8'h41);
    wait_clk(13*OVS*VDIV);

    wr(1'b0, cw(2'b10, 1'b0, 1'b0, 1'b0));
    mon_bitclk = OVS * FDIV;
    exp_q.push_back({1'b1, 1'b0, 8'hC3});
    wr(1'b1, 8'hC3);
    wait_clk(13*OVS*FDIV);

    // R3 off mode sends nothing
    wr(1'b0, cw(2'b00, 1'b0, 1'b0, 1'b0));
    wr(1'b1, 8'h00);
    lows = 0;
    for (int k = 0; k < 12*OVS*VDIV/8; k++) begin
      wait_clk(8);
      if (txd !== 1'b1) lows++;
    end
    chk(lows == 0, "R3 off mode line idle", lows, 32'd0);
    rd(1'b0, v); chk(v[1] == 1'b0, "R3 off mode no tx flag", {24'd0, v}, 32'h00);
    chk(exp_q.size() == 0, "R7 all frames seen", exp_q.size(), 32'd0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule